// File: doc/BRIEF.md
# Handshake Vector Clock-Domain Crossing

This block carries a multi-bit value from a source clock domain to an unrelated destination clock domain. The value is expected to change only now and then, for example a configuration word or a status snapshot. The source side offers a load strobe, a data input and a busy flag. When the block is idle, a load captures the data into a source-domain holding register and starts a four-phase request/acknowledge exchange. The destination side presents the captured word together with a valid pulse that lasts one cycle.

The request is a level from a source flop. It is synchronized into the destination domain through two flops. The destination captures the held word when it sees that level rise, and it answers with an acknowledge level that follows the synchronized request. The acknowledge returns through two source-domain flops. The source lowers its request once the acknowledge arrives. It then waits for the acknowledge to fall again before it accepts new data. The holding register therefore stays unchanged for as long as the destination could be sampling it, so the transfer is safe at any ratio between the two clocks.

Each domain has its own active-low reset. Asserting a reset clears that domain at once, and its release is synchronized to that domain's clock.

Top module: `vec_handshake_cdc`

## Requirements
- R1: While reset is held and just after it is released, `src_busy` is 0, `dst_valid` is 0 and `dst_data` is all zeros.
- R2: A `src_load` sampled high on a source clock edge while `src_busy` is 0 captures `src_data`, and `src_busy` reads 1 after that same edge.
- R3: A `src_load` sampled while `src_busy` is 1 has no effect: its data never reaches `dst_data`, and the held word stays stable until the handshake completes.
- R4: Every accepted word appears on `dst_data` exactly once. Each appearance is marked by a `dst_valid` pulse of exactly one destination cycle, and words arrive in the order they were accepted.
- R5: `dst_data` changes only in a cycle where `dst_valid` is 1, and it holds its value between pulses.
- R6: `src_busy` returns to 0 only after the destination has delivered the word and the synchronized acknowledge has gone back low.
- R7: Transfers are delivered correctly whether the destination clock is slower or faster than the source clock.
- R8: Request and acknowledge each cross their domain boundary through a synchronizer of two flops, with the depth set by a parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_load | input | 1 | Strobe that requests a transfer of `src_data` |
| src_data | input | DATA_W | Word to transfer |
| src_busy | output | 1 | High while a transfer is in progress; loads are ignored while it is high |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_data | output | DATA_W | Last word delivered |
| dst_valid | output | 1 | One-cycle pulse marking a new word on `dst_data` |

## Verification
The two events that can fall in the same source cycle are a new load strobe and the end of the previous handshake. The bench provokes this by holding `src_load` high without a break while it changes `src_data` on every cycle. The load therefore collides with the last busy cycle and with the first idle one. The scoreboard expects only the word that was present in the first cycle `src_busy` was seen low, and any word taken one cycle early or late shows up as a mismatch at `dst_data`. This is repeated with the destination clock slower than, faster than, and close to the source clock.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_REQ_HIGH = 2'd1,
    ST_REQ_LOW  = 2'd2
  } src_st_e;
endpackage

// File: rtl/hs_sync.sv
// Multi-stage flop synchronizer with asynchronous active-low clear.
module hs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

  initial begin
    a_stages_r8: assert (STAGES >= 2);
  end
endmodule

// File: rtl/hs_src.sv
// Source side: holding register and four-phase request state machine.
module hs_src
  import hs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              ack_async,
  output logic              req,
  output logic [DATA_W-1:0] data_q,
  output logic              busy
);
  src_st_e st, st_nxt;
  logic    ack_s;
  logic    take;

  hs_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_async), .q(ack_s)
  );

  always_comb begin
    st_nxt = st;
    take   = 1'b0;
    case (st)
      ST_IDLE: if (load) begin
        take   = 1'b1;
        st_nxt = ST_REQ_HIGH;
      end
      ST_REQ_HIGH: if (ack_s)  st_nxt = ST_REQ_LOW;
      ST_REQ_LOW:  if (!ack_s) st_nxt = ST_IDLE;
      default:                 st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (take) data_q <= din;
  end

  assign req  = (st == ST_REQ_HIGH);
  assign busy = (st != ST_IDLE);

  p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load) |=> (busy && req));
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(data_q));
  p_busy_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !ack_s);
  p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> ack_s);
endmodule

// File: rtl/hs_dst.sv
// Destination side: request edge detect, capture, acknowledge.
module hs_dst #(
  parameter int DATA_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_async,
  input  logic [DATA_W-1:0] data_async,
  output logic              ack,
  output logic [DATA_W-1:0] dout,
  output logic              valid
);
  logic req_s;
  logic req_seen;
  logic rise;

  hs_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_async), .q(req_s)
  );

  assign rise = req_s && !req_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      valid    <= 1'b0;
    end else begin
      req_seen <= req_s;
      valid    <= rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (rise) dout <= data_async;
  end

  assign ack = req_seen;

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_valid_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ack);
  p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(dout));
endmodule

// File: rtl/vec_handshake_cdc.sv
module vec_handshake_cdc #(
  parameter int DATA_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_load,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_busy,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_valid
);
  logic              src_rst_sn, dst_rst_sn;
  logic              req, ack;
  logic [DATA_W-1:0] held;

  // Reset release synchronized per domain.
  hs_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_src_rst (
    .clk(src_clk), .rst_n(src_rst_n), .d(1'b1), .q(src_rst_sn)
  );
  hs_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_dst_rst (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(1'b1), .q(dst_rst_sn)
  );

  hs_src #(.DATA_W(DATA_W), .SYNC_DEPTH(SYNC_DEPTH)) u_src (
    .clk(src_clk), .rst_n(src_rst_sn), .load(src_load), .din(src_data),
    .ack_async(ack), .req(req), .data_q(held), .busy(src_busy)
  );

  hs_dst #(.DATA_W(DATA_W), .SYNC_DEPTH(SYNC_DEPTH)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_sn), .req_async(req), .data_async(held),
    .ack(ack), .dout(dst_data), .valid(dst_valid)
  );
endmodule

// File: tb/vec_handshake_cdc_tb.sv
module vec_handshake_cdc_tb;
  localparam int W = 16;

  logic         src_clk = 0, dst_clk = 0;
  logic         src_rst_n = 0, dst_rst_n = 0;
  logic         src_load = 0;
  logic [W-1:0] src_data = '0;
  logic         src_busy, dst_valid;
  logic [W-1:0] dst_data;

  int dst_half = 37;
  int n_chk = 0, n_bad = 0;
  int n_push = 0, n_pop = 0;
  logic [W-1:0] exp_q[$];
  bit mon_on = 0;
  bit done = 0;

  always #10 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  vec_handshake_cdc #(.DATA_W(W)) u_dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_load(src_load),
    .src_data(src_data), .src_busy(src_busy), .dst_clk(dst_clk),
    .dst_rst_n(dst_rst_n), .dst_data(dst_data), .dst_valid(dst_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops and compares on every valid pulse (R4, R5).
  logic         prev_valid = 0;
  logic [W-1:0] last_data = '0;
  always @(negedge dst_clk) begin
    if (mon_on) begin
      if (dst_valid) begin
        chk(!prev_valid, "R4 pulse width", 1, 0);
        if (exp_q.size() == 0) chk(0, "R3 unexpected word", int'(dst_data), 0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(dst_data == e, "R4 order/data", int'(dst_data), int'(e));
        end
        n_pop++;
      end else if (dst_data != last_data) begin
        chk(0, "R5 hold", int'(dst_data), int'(last_data));
      end
      last_data  = dst_data;
      prev_valid = dst_valid;
    end
  end

  // Driver: one phase of traffic. dense=1 keeps load high every cycle.
  task automatic drive(input int cycles, input bit dense, input int seed);
    bit prev_busy = 0;
    bit expect_busy = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge src_clk);
      if (expect_busy) chk(src_busy == 1'b1, "R2 busy after load", src_busy, 1);
      if (prev_busy && !src_busy)
        chk(n_pop == n_push, "R6 busy fall after delivery", n_pop, n_push);
      prev_busy   = src_busy;
      src_data    = W'(seed + i * 16'h3a5 + (i >> 2));
      src_load    = dense ? 1'b1 : ((i % 23) == 0 || (i % 23) == 5);
      expect_busy = 0;
      if (src_load && !src_busy) begin
        exp_q.push_back(src_data);
        n_push++;
        expect_busy = 1;
      end
    end
    @(negedge src_clk);
    src_load = 0;
    // Drain: wait for handshake to finish, then for delivery.
    for (int k = 0; k < 2000 && (src_busy || exp_q.size() != 0); k++) @(negedge src_clk);
    chk(exp_q.size() == 0, "R7 all delivered", exp_q.size(), 0);
    chk(!src_busy, "R6 idle at end", src_busy, 0);
  endtask

  initial begin
    fork
      begin
        repeat (6) @(negedge src_clk);
        // R1: reset state while held
        chk(src_busy == 0, "R1 busy in reset", src_busy, 0);
        chk(dst_valid == 0, "R1 valid in reset", dst_valid, 0);
        chk(dst_data == '0, "R1 data in reset", int'(dst_data), 0);
        src_rst_n = 1; dst_rst_n = 1;
        repeat (6) @(negedge src_clk);
        chk(src_busy == 0, "R1 busy after reset", src_busy, 0);
        chk(dst_data == '0, "R1 data after reset", int'(dst_data), 0);
        mon_on = 1;
        // R3: loads held high collide with handshake end; slow destination (R7)
        dst_half = 37; drive(400, 1, 16'h1111);
        // R7: fast destination
        dst_half = 4;  drive(400, 1, 16'h2222);
        dst_half = 4;  drive(300, 0, 16'h3333);
        // R7: near-equal clocks, sparse loads
        dst_half = 11; drive(400, 0, 16'h4444);
        dst_half = 11; drive(300, 1, 16'h5555);
        chk(n_pop == n_push, "R4 count", n_pop, n_push);
        chk(n_push > 20, "R2 enough accepted", n_push, 21);
        done = 1;
      end
      begin
        repeat (150000) @(posedge src_clk);
        if (!done) chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule